// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block receives configuration words over a three-wire, write-only serial port (data, shift clock, active-low enable) and places each word into one of a small bank of parallel configuration latches. While the enable is low, every rising edge of the shift clock moves one bit into a 21-bit shift register, most significant bit first. When the enable returns high, the low four bits of the shift register are taken as an address and the upper seventeen bits as data. The data is then copied into the latch that the address selects.

All three serial lines are brought into the system clock domain through two-flop synchronizers, and their edges are found there. A load is never issued while the downstream dividers report that they are sampling their ratios (`div_busy`). Instead the request waits and is issued on the first cycle after `div_busy` falls. Addresses reserved for test use, and addresses with no latch behind them, write nothing and set a sticky error flag.

The control state machine has four states. ST_IDLE: the port is quiet; it goes to ST_SHIFT when the synchronized enable is low, or to ST_DECODE on an enable rising edge. ST_SHIFT: a frame is being clocked in; it goes to ST_DECODE on the enable rising edge, which also captures the frame. ST_DECODE: the address is judged; a bad address sets the error and goes to ST_IDLE, a good address with `div_busy` low strobes and goes to ST_IDLE, and a good address with `div_busy` high goes to ST_HOLD. ST_HOLD: a load is pending; it strobes and goes to ST_IDLE on the first cycle with `div_busy` low, or goes back to ST_DECODE if a newer frame completes first.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, every latch reads 0, `err_flag` is 0 and `load_strobe` is 0.
- R2: Shift-clock rising edges that occur while `ser_en_n` is high do not change the shift register. A later short frame therefore builds only on bits that were clocked in while the enable was low.
- R3: Bits enter most significant first and only the last 21 bits clocked in are kept. A frame of more than 21 bits is accepted, and its leading extra bits are discarded.
- R4: Of the 21 retained bits, bits [3:0] are the address and bits [20:4] are the data. Latch k (k = 0..3) sits at address k+1. A latch changes only when its strobe is raised.
- R5: If the address is assigned and `div_busy` is low, the latch takes its new value at the fourth rising system-clock edge after the enable rise is presented at the input. `load_strobe` is high for exactly the one cycle before that edge.
- R6: An enable rise that arrives while the shift clock is still high loads normally and does not add a bit to the frame.
- R7: While `div_busy` is high, no strobe is raised. A pending load is strobed in the first cycle in which `div_busy` is low, and the latch updates at the end of that cycle.
- R8: If a second frame completes while a load is still pending, the second frame replaces the first, and the first frame's latch is left unchanged.
- R9: Addresses 14 and 15 (forbidden) and addresses 0 and 5..13 (unassigned) write no latch and set `err_flag`. The flag stays set through later valid loads and is cleared only by reset.
- R10: At most one bit of `load_strobe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock |
| ser_en_n | input | 1 | Active-low frame enable |
| div_busy | input | 1 | High while dividers sample their ratios; blocks loading |
| load_strobe | output | 4 | One-cycle write strobe, one bit per latch |
| cfg_q | output | 68 | Latch contents, latch k in bits [17k+16:17k] |
| err_flag | output | 1 | Sticky flag for a forbidden or unassigned address |

## Verification
Full 21-bit frames are sent to each of the four addresses to confirm the field split and the address map. Longer frames show that leading bits are dropped, while four-bit frames sent after shift-clock pulses with the enable high show whether any bits leaked in while the port was idle. Holding `div_busy` high across one frame, and then across two frames, separates a load that is dropped from one that is delayed and from one that is superseded. Frames to test and unassigned addresses, followed by valid frames, show that the error flag is set, that it stays set, and that no latch is written.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;

    localparam int DEF_DATA_W = 17;
    localparam int DEF_ADDR_W = 4;
    localparam int DEF_NREG   = 4;
    localparam int DEF_BASE   = 1;
    localparam int DEF_FORBID = 14;
    localparam int DEF_STAGES = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_DECODE = 2'd2,
        ST_HOLD   = 2'd3
    } ldr_state_e;

endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= {stage_q[STAGES-2:0], din};
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_shifter.sv
`timescale 1ns/1ps
module cfg_shifter #(
    parameter int FRAME_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_s,
    input  logic               sclk_s,
    input  logic               data_s,
    output logic [FRAME_W-1:0] shift_q,
    output logic               en_rise
);

    logic sclk_d;
    logic en_d;
    logic take_bit;

    // a bit is taken only on a shift-clock rise seen while enable is low
    assign take_bit = !en_s && sclk_s && !sclk_d;
    assign en_rise  = en_s && !en_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            en_d    <= 1'b1;
            shift_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            en_d   <= en_s;
            if (take_bit) begin
                shift_q <= {shift_q[FRAME_W-2:0], data_s};
            end
        end
    end

endmodule

// File: rtl/cfg_load_fsm.sv
`timescale 1ns/1ps
module cfg_load_fsm
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W     = 17,
    parameter int ADDR_W     = 4,
    parameter int NREG       = 4,
    parameter int LATCH_BASE = 1,
    parameter int FORBID_LO  = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_rise,
    input  logic                     en_s,
    input  logic                     div_busy,
    input  logic [DATA_W+ADDR_W-1:0] shift_q,
    output logic [NREG-1:0]          load_strobe,
    output logic [DATA_W-1:0]        load_data,
    output logic                     err_flag
);

    localparam int                FRAME_W  = DATA_W + ADDR_W;
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(LATCH_BASE);
    localparam logic [ADDR_W:0]   END_A    = (ADDR_W+1)'(LATCH_BASE + NREG);
    localparam logic [ADDR_W-1:0] FORBID_A = ADDR_W'(FORBID_LO);

    ldr_state_e         state_q;
    ldr_state_e         state_d;
    logic [FRAME_W-1:0] frame_q;
    logic [ADDR_W-1:0]  addr;
    logic [ADDR_W-1:0]  offset;
    logic               hit;
    logic               issue;
    logic               err_set;

    assign addr      = frame_q[ADDR_W-1:0];
    assign load_data = frame_q[FRAME_W-1:ADDR_W];
    assign offset    = addr - BASE_A;
    assign hit       = (addr >= BASE_A) && ({1'b0, addr} < END_A) && (addr < FORBID_A);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame capture on the enable rise, error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q  <= '0;
            err_flag <= 1'b0;
        end else begin
            if (en_rise) begin
                frame_q <= shift_q;
            end
            if (err_set) begin
                err_flag <= 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_rise) begin
                    state_d = ST_DECODE;
                end else if (!en_s) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (en_rise) begin
                    state_d = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (!hit) begin
                    state_d = ST_IDLE;
                end else if (div_busy) begin
                    state_d = ST_HOLD;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (en_rise) begin
                    state_d = ST_DECODE;
                end else if (!div_busy) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        issue   = 1'b0;
        err_set = 1'b0;
        unique case (state_q)
            ST_DECODE: begin
                err_set = !hit;
                issue   = hit && !div_busy;
            end
            ST_HOLD: begin
                issue = !en_rise && !div_busy;
            end
            default: begin
                issue   = 1'b0;
                err_set = 1'b0;
            end
        endcase
        load_strobe = issue ? (NREG'(1) << offset) : '0;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank #(
    parameter int DATA_W = 17,
    parameter int NREG   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREG-1:0]              load_strobe,
    input  logic [DATA_W-1:0]            load_data,
    output logic [NREG-1:0][DATA_W-1:0]  cfg_q
);

    for (genvar k = 0; k < NREG; k++) begin : g_latch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[k] <= '0;
            end else if (load_strobe[k]) begin
                cfg_q[k] <= load_data;
            end
        end
    end

endmodule

// File: rtl/cfg_serial_loader.sv
`timescale 1ns/1ps
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int NREG       = DEF_NREG,
    parameter int LATCH_BASE = DEF_BASE,
    parameter int FORBID_LO  = DEF_FORBID,
    parameter int SYNC_STAGES = DEF_STAGES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_data,
    input  logic                        ser_clk,
    input  logic                        ser_en_n,
    input  logic                        div_busy,
    output logic [NREG-1:0]             load_strobe,
    output logic [NREG-1:0][DATA_W-1:0] cfg_q,
    output logic                        err_flag
);

    localparam int FRAME_W = DATA_W + ADDR_W;

    logic               en_sync;
    logic               sclk_sync;
    logic               data_sync;
    logic               en_rise;
    logic [FRAME_W-1:0] shift_q;
    logic [DATA_W-1:0]  load_data;

    cfg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_en_n, ser_clk, ser_data}),
        .dout ({en_sync, sclk_sync, data_sync})
    );

    cfg_shifter #(
        .FRAME_W(FRAME_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_s   (en_sync),
        .sclk_s (sclk_sync),
        .data_s (data_sync),
        .shift_q(shift_q),
        .en_rise(en_rise)
    );

    cfg_load_fsm #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NREG      (NREG),
        .LATCH_BASE(LATCH_BASE),
        .FORBID_LO (FORBID_LO)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_rise    (en_rise),
        .en_s       (en_sync),
        .div_busy   (div_busy),
        .shift_q    (shift_q),
        .load_strobe(load_strobe),
        .load_data  (load_data),
        .err_flag   (err_flag)
    );

    cfg_reg_bank #(
        .DATA_W(DATA_W),
        .NREG  (NREG)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_strobe(load_strobe),
        .load_data  (load_data),
        .cfg_q      (cfg_q)
    );

endmodule

// File: rtl/cfg_serial_loader_chk.sv
`timescale 1ns/1ps
module cfg_serial_loader_chk #(
    parameter int DATA_W  = 17,
    parameter int NREG    = 4,
    parameter int FRAME_W = 21
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        div_busy,
    input logic [NREG-1:0]             load_strobe,
    input logic [NREG-1:0][DATA_W-1:0] cfg_q,
    input logic                        err_flag,
    input logic                        en_s,
    input logic [FRAME_W-1:0]          shift_q
);

    // R2: no bit is taken while the synchronized enable is high
    a_r2_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        en_s |=> $stable(shift_q));

    // R10: never more than one latch strobed
    a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_strobe));

    // R7: busy blocks every strobe
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> (load_strobe == '0));

    // R9: error flag is sticky until reset
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R4: latches move only under a strobe
    a_r4_latch_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe == '0) |=> $stable(cfg_q));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
    .DATA_W (DATA_W),
    .NREG   (NREG),
    .FRAME_W(FRAME_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_busy   (div_busy),
    .load_strobe(load_strobe),
    .cfg_q      (cfg_q),
    .err_flag   (err_flag),
    .en_s       (en_sync),
    .shift_q    (shift_q)
);

// File: tb/cfg_serial_loader_test.sv
`timescale 1ns/1ps
module cfg_serial_loader_test;

    localparam int NR = 4;
    localparam int DW = 17;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sdata = 1'b0;
    logic               sclk = 1'b0;
    logic               sen_n = 1'b1;
    logic               busy = 1'b0;
    logic [NR-1:0]      load_strobe;
    logic [NR-1:0][DW-1:0] cfg_q;
    logic               err_flag;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    int cyc = 0;

    // behavioural reference model
    logic [20:0]   m_sh = '0;
    logic [20:0]   m_pend = '0;
    bit            m_pv = 0;
    int            m_due = 0;
    logic [DW-1:0] m_q [NR];
    bit            m_err = 0;

    cfg_serial_loader uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_data   (sdata),
        .ser_clk    (sclk),
        .ser_en_n   (sen_n),
        .div_busy   (busy),
        .load_strobe(load_strobe),
        .cfg_q      (cfg_q),
        .err_flag   (err_flag)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit addr_ok(input logic [3:0] a);
        return (a >= 4'd1) && (a <= 4'd4);
    endfunction

    // model clock step
    always @(posedge clk) begin
        logic [3:0] a;
        cyc++;
        if (rst_n && m_pv && cyc >= m_due) begin
            a = m_pend[3:0];
            if (!addr_ok(a)) begin
                m_err = 1;
                m_pv  = 0;
            end else if (!busy) begin
                m_q[a-1] = m_pend[20:4];
                m_pv     = 0;
            end
        end
    end

    // compare on every clock, away from the edge
    always @(negedge clk) begin
        logic [NR-1:0] es;
        #1;
        es = '0;
        if (m_pv && (cyc + 1 >= m_due) && addr_ok(m_pend[3:0]) && !busy)
            es = NR'(1) << (m_pend[3:0] - 4'd1);
        for (int i = 0; i < NR; i++) chk("R4 per-cycle latch", cfg_q[i], m_q[i]);
        chk("R5 per-cycle strobe", load_strobe, es);
        chk("R9 per-cycle err", err_flag, m_err);
        chk("R10 strobe count", ($countones(load_strobe) <= 1), 1'b1);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        m_sh = '0; m_pv = 0; m_err = 0;
        for (int i = 0; i < NR; i++) m_q[i] = '0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic send(input logic [63:0] bits, input int n, input bit end_high, input int settle);
        sen_n = 1'b0;
        idle(3);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = bits[i];
            sclk  = 1'b0;
            idle(3);
            sclk  = 1'b1;
            idle(3);
            m_sh = {m_sh[19:0], bits[i]};
        end
        if (!end_high) begin
            sclk = 1'b0;
            idle(3);
        end
        sen_n  = 1'b1;
        m_pend = m_sh;
        m_pv   = 1;
        m_due  = cyc + 4;
        idle(settle);
    endtask

    function automatic logic [63:0] mk(input logic [16:0] d, input logic [3:0] a);
        return {43'd0, d, a};
    endfunction

    initial begin
        logic [16:0] da;
        for (int i = 0; i < NR; i++) m_q[i] = '0;
        idle(3);
        // R1 reset state
        chk("R1 latches", cfg_q, '0);
        chk("R1 err", err_flag, 1'b0);
        chk("R1 strobe", load_strobe, '0);
        rst_n = 1'b1;
        idle(3);

        // R4 field split and address map
        send(mk(17'h1ABCD, 4'd1), 21, 0, 8);
        send(mk(17'h00123, 4'd2), 21, 0, 8);
        send(mk(17'h10001, 4'd3), 21, 0, 8);
        send(mk(17'h0FEDC, 4'd4), 21, 0, 8);
        #1;
        chk("R4 latch0", cfg_q[0], 17'h1ABCD);
        chk("R4 latch1", cfg_q[1], 17'h00123);
        chk("R4 latch2", cfg_q[2], 17'h10001);
        chk("R4 latch3", cfg_q[3], 17'h0FEDC);

        // R5 latency
        send(mk(17'h05555, 4'd1), 21, 0, 3);
        #1;
        chk("R5 strobe cycle", load_strobe, 4'b0001);
        chk("R5 old value before edge", cfg_q[0], 17'h1ABCD);
        idle(1);
        #1;
        chk("R5 new value", cfg_q[0], 17'h05555);
        chk("R5 strobe single cycle", load_strobe, 4'b0000);

        // R3 long frame keeps last 21 bits
        send({34'd0, 9'h1FF, 17'h0F0F0, 4'd2}, 30, 0, 8);
        #1;
        chk("R3 long frame", cfg_q[1], 17'h0F0F0);

        // R2 idle pulses then short frame
        da = 17'h15A5A;
        send(mk(da, 4'd4), 21, 0, 8);
        sdata = 1'b1;
        for (int p = 0; p < 6; p++) begin
            sclk = 1'b0; idle(3);
            sclk = 1'b1; idle(3);
        end
        sclk = 1'b0;
        idle(3);
        send(64'h1, 4, 0, 8);
        #1;
        chk("R2 short frame after idle pulses", cfg_q[0], {da[12:0], 4'd4});
        chk("R2 latch3 kept", cfg_q[3], da);

        // R6 enable rise with shift clock high
        send(mk(17'h1F00F, 4'd3), 21, 1, 8);
        #1;
        chk("R6 end high", cfg_q[2], 17'h1F00F);

        // R7 busy defers the load
        busy = 1'b1;
        send(mk(17'h0AAAA, 4'd3), 21, 0, 10);
        #1;
        chk("R7 held while busy", cfg_q[2], 17'h1F00F);
        chk("R7 no strobe while busy", load_strobe, 4'b0000);
        idle(1);
        busy = 1'b0;
        #1;
        chk("R7 strobe after busy", load_strobe, 4'b0100);
        idle(1);
        #1;
        chk("R7 loaded after busy", cfg_q[2], 17'h0AAAA);

        // R8 newer frame replaces a pending one
        busy = 1'b1;
        send(mk(17'h13579, 4'd1), 21, 0, 8);
        send(mk(17'h02468, 4'd2), 21, 0, 4);
        busy = 1'b0;
        idle(3);
        #1;
        chk("R8 first frame dropped", cfg_q[0], {da[12:0], 4'd4});
        chk("R8 second frame loaded", cfg_q[1], 17'h02468);

        // R9 forbidden and unassigned addresses
        send(mk(17'h1FFFF, 4'hF), 21, 0, 8);
        #1;
        chk("R9 err on forbidden", err_flag, 1'b1);
        chk("R9 no write latch3", cfg_q[3], da);
        chk("R9 no write latch2", cfg_q[2], 17'h0AAAA);
        send(mk(17'h00001, 4'd1), 21, 0, 8);
        #1;
        chk("R9 err sticky", err_flag, 1'b1);
        chk("R9 valid load still works", cfg_q[0], 17'h00001);
        do_reset();
        #1;
        chk("R1 err cleared by reset", err_flag, 1'b0);
        chk("R1 latches cleared", cfg_q, '0);
        send(mk(17'h00007, 4'hE), 21, 0, 8);
        #1;
        chk("R9 err on addr 14", err_flag, 1'b1);
        chk("R9 addr 14 writes nothing", cfg_q, '0);
        do_reset();
        send(mk(17'h12345, 4'h9), 21, 0, 8);
        #1;
        chk("R9 err on unassigned", err_flag, 1'b1);
        chk("R9 unassigned writes nothing", cfg_q, '0);
        send(mk(17'h00042, 4'h0), 21, 0, 8);
        #1;
        chk("R9 addr 0 writes nothing", cfg_q, '0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule